// File: doc/BRIEF.md
# Serial Diagnostic Slave with Whole-Byte Frame Check

This block is a full-duplex serial slave port. A host lowers the select line, clocks bits in and out, then raises select. Data on the input line is taken on falling clock edges. The output bit changes on rising clock edges. Both directions run most significant bit first. When select falls, the block loads a byte of sticky fault flags into its 8-bit shift register, so the host reads the fault status while it writes a command byte.

A frame is accepted only if the number of clock pulses is a non-zero whole multiple of eight. On acceptance, the last byte shifted in is copied to an output register, a one-cycle strobe is given, and the fault flags are cleared. Frames of any other length leave the output register and the flags as they were. The shift register works as a plain eight-stage delay line, so several devices can share one select line in a chain. Each device keeps the final byte that it holds.

All pins are sampled by a fast system clock through two-stage synchronizers. The serial clock must run at no more than a quarter of the system clock rate. The serial output leaves as a data bit and an enable bit. A pad drives high impedance whenever the enable is low.

Top module: `sdl_spi_slave`

## Requirements
- R1: While select (cs_n) is high, so_oe is 0, so the serial output is high impedance. so_oe rises only after cs_n falls.
- R2: Input bits are taken on falling edges of sclk and so_o changes only on rising edges of sclk (or when select falls). Both directions are MSB first.
- R3: When cs_n falls, the current flags are loaded into the shift register, so the first bit on so_o is flags bit 7 and the first 8 bits read are the flags byte.
- R4: At the rising edge of cs_n, a frame of 8, 16, 24... falling sclk edges puts the last 8 bits received into rx_data and pulses rx_valid high for exactly one system clock.
- R5: A frame with zero falling sclk edges, or with a count that is not a multiple of 8, is discarded: no rx_valid, rx_data unchanged, flags not cleared.
- R6: An accepted frame clears the flags. A fault_set bit that is high in the same cycle as the clear stays set.
- R7: A bit taken from si appears on so_o eight sclk periods later, so in a 16-bit frame the second byte read equals the first byte written.
- R8: Each flag bit is set by a one-cycle pulse on its fault_set bit and stays set until a frame is accepted.
- R9: After the synchronous reset, rx_data is 8'h00, rx_valid is 0, so_oe is 0 and all flags are 0.
- R10: sclk and si activity while cs_n is high has no effect: no rx_valid, rx_data unchanged, so_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Select, active low |
| sclk | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| fault_set | input | 8 | One-cycle pulses that set the sticky flags |
| so_o | output | 1 | Serial data out bit |
| so_oe | output | 1 | Output enable for the serial data pad |
| rx_data | output | 8 | Last accepted byte |
| rx_valid | output | 1 | One-cycle strobe when rx_data is updated |

## Verification
The hardest case to reach from the ports is a fault pulse that arrives in the very system clock where an accepted frame clears the flags. The bench counts the synchronizer stages from the moment it raises select and asserts the fault for exactly that one cycle. It confirms the timing by seeing rx_valid high at that point, then reads the flags in a 9-bit frame, which is too long to be accepted. The same non-accepted read frame lets the bench check flags after each scenario without clearing them.

// File: rtl/sdl_spi_pkg.sv
package sdl_spi_pkg;

    localparam int WORD_W     = 8;
    localparam int SYNC_DEPTH = 2;
    localparam int PIN_COUNT  = 3;

    typedef logic [WORD_W-1:0] word_t;

    // Synchronized level plus single-cycle edge events of one input pin
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } pin_evt_t;

    typedef enum int {
        PIN_CSN  = 0,
        PIN_SCLK = 1,
        PIN_SI   = 2
    } pin_idx_e;

    // Sticky flag update: a set in the clear cycle survives
    function automatic word_t flags_next(word_t cur, word_t set, logic clr);
        return (clr ? '0 : cur) | set;
    endfunction

endpackage

// File: rtl/sdl_pin_sync.sv
module sdl_pin_sync
    import sdl_spi_pkg::*;
#(
    parameter int   DEPTH   = SYNC_DEPTH,
    parameter logic RST_VAL = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_i,
    output pin_evt_t evt_o
);

    // chain[DEPTH-1] is the synchronized level, chain[DEPTH] its previous value
    logic [DEPTH:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {(DEPTH+1){RST_VAL}};
        end else begin
            chain <= {chain[DEPTH-1:0], pin_i};
        end
    end

    always_comb begin
        evt_o.lvl  = chain[DEPTH-1];
        evt_o.rise = chain[DEPTH-1] & ~chain[DEPTH];
        evt_o.fall = ~chain[DEPTH-1] & chain[DEPTH];
    end

endmodule

// File: rtl/sdl_diag_flags.sv
module sdl_diag_flags
    import sdl_spi_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flags_o
);

    logic [W-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (clr_i ? '0 : flags_q) | set_i;
        end
    end

    assign flags_o = flags_q;

    // R6 / R8: every set pulse is present in the next cycle, clear or not
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R8: without set or clear the flags hold
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && set_i == '0) |=> $stable(flags_q));

endmodule

// File: rtl/sdl_frame_shifter.sv
module sdl_frame_shifter
    import sdl_spi_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  pin_evt_t     cs_evt,
    input  pin_evt_t     sclk_evt,
    input  logic         si_lvl,
    input  logic [W-1:0] load_i,
    output logic         so_bit_o,
    output logic         so_oe_o,
    output logic [W-1:0] rx_data_o,
    output logic         rx_valid_o,
    output logic         accept_o
);

    localparam int                CNT_W    = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(W - 1);

    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             whole_seen;
    logic             frame_act;
    logic             so_q;
    logic [W-1:0]     rx_q;
    logic             valid_q;
    logic             accept;

    // cs_evt.fall is active-low select going active; rise ends the frame
    assign accept = frame_act & cs_evt.rise & whole_seen & (bit_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            whole_seen <= 1'b0;
            frame_act  <= 1'b0;
            so_q       <= 1'b0;
            rx_q       <= '0;
            valid_q    <= 1'b0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                rx_q <= shreg;
            end
            if (cs_evt.fall) begin
                frame_act  <= 1'b1;
                shreg      <= load_i;
                so_q       <= load_i[W-1];
                bit_cnt    <= '0;
                whole_seen <= 1'b0;
            end else if (cs_evt.rise) begin
                frame_act <= 1'b0;
            end else if (frame_act) begin
                if (sclk_evt.fall) begin
                    shreg <= {shreg[W-2:0], si_lvl};
                    if (bit_cnt == CNT_LAST) begin
                        bit_cnt    <= '0;
                        whole_seen <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (sclk_evt.rise) begin
                    so_q <= shreg[W-1];
                end
            end
        end
    end

    assign so_bit_o   = so_q;
    assign so_oe_o    = frame_act;
    assign rx_data_o  = rx_q;
    assign rx_valid_o = valid_q;
    assign accept_o   = accept;

    // R4: strobe lasts one cycle
    a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R4: strobe only follows the end of a frame
    a_r4_valid_after_end: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(cs_evt.rise));

    // R5: output register moves only together with the strobe
    a_r5_data_only_on_valid: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_q) |-> valid_q);

    // R5: a frame ending mid-byte is never accepted
    a_r5_partial_rejected: assert property (@(posedge clk) disable iff (rst)
        (cs_evt.rise && bit_cnt != '0) |=> !valid_q);

    // R2: output bit changes only after a clock rise or select fall
    a_r2_so_on_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(so_q) |-> $past(sclk_evt.rise || cs_evt.fall));

endmodule

// File: rtl/sdl_spi_slave.sv
module sdl_spi_slave
    import sdl_spi_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int SYNC  = SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         si,
    input  logic [W-1:0] fault_set,
    output logic         so_o,
    output logic         so_oe,
    output logic [W-1:0] rx_data,
    output logic         rx_valid
);

    logic [PIN_COUNT-1:0] pin_raw;
    pin_evt_t             pin_evt [PIN_COUNT];
    logic [W-1:0]         flags;
    logic                 accept;

    assign pin_raw[PIN_CSN]  = cs_n;
    assign pin_raw[PIN_SCLK] = sclk;
    assign pin_raw[PIN_SI]   = si;

    generate
        for (genvar g = 0; g < PIN_COUNT; g++) begin : g_sync
            sdl_pin_sync #(
                .DEPTH   (SYNC),
                .RST_VAL ((g == PIN_CSN) ? 1'b1 : 1'b0)
            ) i_sync (
                .clk   (clk),
                .rst   (rst),
                .pin_i (pin_raw[g]),
                .evt_o (pin_evt[g])
            );
        end
    endgenerate

    sdl_diag_flags #(.W(W)) i_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (fault_set),
        .clr_i   (accept),
        .flags_o (flags)
    );

    sdl_frame_shifter #(.W(W)) i_shift (
        .clk        (clk),
        .rst        (rst),
        .cs_evt     (pin_evt[PIN_CSN]),
        .sclk_evt   (pin_evt[PIN_SCLK]),
        .si_lvl     (pin_evt[PIN_SI].lvl),
        .load_i     (flags),
        .so_bit_o   (so_o),
        .so_oe_o    (so_oe),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .accept_o   (accept)
    );

    // R1: select held high for two synchronized cycles leaves the output disabled
    a_r1_hiz_when_idle: assert property (@(posedge clk) disable iff (rst)
        (pin_evt[PIN_CSN].lvl && $past(pin_evt[PIN_CSN].lvl)) |-> !so_oe);

    // R6: flags are empty after a clear with no coincident set
    a_r6_clear_on_accept: assert property (@(posedge clk) disable iff (rst)
        (accept && fault_set == '0) |=> (flags == '0));

endmodule

// File: tb/test_sdl_spi_slave.sv
module test_sdl_spi_slave;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       si = 1'b0;
    logic [7:0] fault_set = '0;
    logic       so_o;
    logic       so_oe;
    logic [7:0] rx_data;
    logic       rx_valid;

    int nchk  = 0;
    int nerr  = 0;
    int vcnt  = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    sdl_spi_slave i_sdl_spi_slave (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .si        (si),
        .fault_set (fault_set),
        .so_o      (so_o),
        .so_oe     (so_oe),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    always @(negedge clk) if (rx_valid) vcnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One frame of nbits, MSB first; late_f is pulsed in the cycle the frame would be accepted
    task automatic xfer(input int nbits, input logic [31:0] tx, input logic [7:0] late_f,
                        output logic [31:0] rx);
        rx = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            si   = tx[i];
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            rx   = {rx[30:0], so_o};
            sclk = 1'b0;
            repeat (4) @(negedge clk);
        end
        cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        fault_set = late_f;
        @(negedge clk);
        fault_set = '0;
        repeat (4) @(negedge clk);
    endtask

    // 9-bit frame: reads the flags without being accepted
    task automatic read_flags(output logic [7:0] f);
        logic [31:0] rx;
        xfer(9, 32'h0, 8'h00, rx);
        f = rx[8:1];
    endtask

    task automatic pulse_fault(input logic [7:0] v);
        @(negedge clk) fault_set = v;
        @(negedge clk) fault_set = '0;
    endtask

    task automatic t_reset;
        logic [7:0] f;
        chk("R9 rx_data", rx_data, 8'h00);
        chk("R9 rx_valid", rx_valid, 1'b0);
        chk("R9 so_oe", so_oe, 1'b0);
        read_flags(f);
        chk("R9 flags", f, 8'h00);
        chk("R5 read frame no valid", vcnt, 0);
    endtask

    task automatic t_idle_ignore;
        int v0 = vcnt;
        int oe_seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) begin sclk = ~sclk; si = ~si; end
            repeat (3) @(negedge clk);
            if (so_oe) oe_seen++;
        end
        sclk = 1'b0; si = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 so_oe while idle", oe_seen, 0);
        chk("R10 no valid while idle", vcnt, v0);
        chk("R10 rx_data unchanged", rx_data, 8'h00);
    endtask

    task automatic t_sticky;
        logic [7:0] f;
        pulse_fault(8'hA5);
        repeat (3) @(negedge clk);
        pulse_fault(8'h10);
        read_flags(f);
        chk("R8 R3 flags read", f, 8'hB5);
        read_flags(f);
        chk("R8 R5 flags kept", f, 8'hB5);
    endtask

    task automatic t_accept;
        logic [31:0] rx;
        logic [7:0]  f;
        int v0 = vcnt;
        xfer(8, 32'h3C, 8'h00, rx);
        chk("R3 first byte out is flags", rx[7:0], 8'hB5);
        chk("R4 rx_data", rx_data, 8'h3C);
        chk("R4 one strobe", vcnt, v0 + 1);
        read_flags(f);
        chk("R6 flags cleared", f, 8'h00);
        chk("R5 9-bit keeps rx_data", rx_data, 8'h3C);
    endtask

    task automatic t_reject;
        logic [31:0] rx;
        logic [7:0]  f;
        int v0;
        pulse_fault(8'h02);
        v0 = vcnt;
        xfer(0, 32'h0, 8'h00, rx);
        chk("R5 zero-length no valid", vcnt, v0);
        xfer(12, 32'hABC, 8'h00, rx);
        chk("R5 12-bit no valid", vcnt, v0);
        chk("R5 12-bit rx_data kept", rx_data, 8'h3C);
        read_flags(f);
        chk("R5 flags kept", f, 8'h02);
    endtask

    task automatic t_daisy;
        logic [31:0] rx;
        int v0 = vcnt;
        xfer(16, 32'hC35A, 8'h00, rx);
        chk("R3 16-bit first byte flags", rx[15:8], 8'h02);
        chk("R7 second byte is first in", rx[7:0], 8'hC3);
        chk("R4 16-bit rx_data", rx_data, 8'h5A);
        chk("R4 16-bit one strobe", vcnt, v0 + 1);
        xfer(24, 32'h123456, 8'h00, rx);
        chk("R7 24-bit delay a", rx[15:8], 8'h12);
        chk("R7 24-bit delay b", rx[7:0], 8'h34);
        chk("R4 24-bit rx_data", rx_data, 8'h56);
    endtask

    task automatic t_set_wins;
        logic [31:0] rx;
        logic [7:0]  f;
        int v0;
        pulse_fault(8'h01);
        v0 = vcnt;
        // xfer pulses 8'h40 in the clear cycle; rx_valid is high one cycle later
        xfer(8, 32'h99, 8'h40, rx);
        chk("R6 accept happened", vcnt, v0 + 1);
        chk("R4 rx_data", rx_data, 8'h99);
        read_flags(f);
        chk("R6 set wins over clear", f, 8'h40);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_sticky();
        t_accept();
        t_reject();
        t_daisy();
        t_set_wins();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule